// File: doc/BRIEF.md
# Quad-Read Boot Loader with Capture-Delay Calibration

This block fetches a boot image from a serial NOR flash. Every transfer it issues is a quad-output fast read at single data rate. The opcode and the address go out on one data line, and the data comes back on four. The flash clock comes from the system clock through a fixed divider: one flash clock period lasts `2*HALF_DIV` system cycles. The flash is read in clock mode 0, so the clock idles low, bits are launched on the falling edge and the flash samples on the rising edge.

Round-trip delay on the board is not known in advance, so a single `start` pulse runs a calibration first. The controller reads a four-byte header sixteen times, once for each value of a 4-bit capture delay, and compares each result with a signature parameter. It keeps the centre of the longest run of passing values. It then reads `byte_count` bytes from address zero, streams them out on a valid-qualified byte port, and pulses `done`. If no delay value passes, `cal_err` is raised and the main read never starts.

The top-level controller has the states C_IDLE, C_CAL_RUN, C_CAL_NEXT, C_MAIN_RUN and C_FINISH, with these transitions:
- C_IDLE to C_CAL_RUN on `start`.
- C_CAL_RUN to C_CAL_NEXT when a header read completes.
- C_CAL_NEXT back to C_CAL_RUN while delay values remain.
- C_CAL_NEXT to C_MAIN_RUN when calibration found a pass and the count is non-zero.
- C_CAL_NEXT to C_FINISH when calibration found a pass and the count is zero.
- C_CAL_NEXT to C_IDLE when calibration found no pass, with the error flag set.
- C_MAIN_RUN to C_FINISH when the main read completes.
- C_FINISH to C_IDLE after one cycle.

The transfer engine has the states X_IDLE, X_CMD, X_ADDR, X_DUMMY, X_DATA, X_DRAIN and X_GAP. It moves through them in that order, one after the next, and returns to X_IDLE at the end of the gap.

Top module: `qspi_boot_reader`

## Requirements
- R1: Each transfer starts with the 8-bit opcode 0x6B followed by a 24-bit address of zero. These 32 bits go out MSB first on io_out[0], and each bit changes while sclk is low. During these bits io_oe equals 4'b0001.
- R2: Exactly 8 dummy clocks follow the address, with io_oe equal to 4'b0000. After them, every clock carries one nibble on io_in[3:0], high nibble of each byte first.
- R3: After reset, cs_n=1, sclk=0, io_oe=0, done=0, cal_err=0 and out_valid=0. sclk is low whenever cs_n is high. While a transfer runs, consecutive rising edges of sclk are 2*HALF_DIV system cycles apart.
- R4: Between two transfers, cs_n stays high for at least 2*HALF_DIV system cycles.
- R5: With capture delay D, a nibble is taken from io_in D system cycles after the falling sclk edge that launched it. D runs from 0 to 15.
- R6: Calibration makes 16 header reads of 4 bytes each, using delays 0, 1, ..., 15 in that order. A read passes only if its bytes equal SIGNATURE, taken most significant byte first.
- R7: The chosen delay is floor((first+last)/2) of the longest run of consecutive passing delays. When runs are equally long, the lowest one wins. The choice appears on cal_delay once calibration has finished.
- R8: If no delay passes, cal_err goes high and stays high until the next accepted start. In that case no main read is issued, out_valid never asserts and done does not pulse.
- R9: The main read returns byte_count bytes from address zero, in order, on out_data with out_valid. done then pulses for one cycle after cs_n has returned high.
- R10: When byte_count is zero, done pulses after calibration and no seventeenth transfer takes place.
- R11: A start pulse that arrives while a run is in progress has no effect on that run or its byte count.
- R12: out_valid stays low throughout calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts calibration and then the boot read (accepted only when idle) |
| byte_count | input | CNT_W | Number of bytes for the main read |
| out_valid | output | 1 | A boot byte is present on out_data |
| out_data | output | 8 | Boot byte |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | No capture delay passed |
| cal_delay | output | 4 | Capture delay (the chosen value after calibration) |
| sclk | output | 1 | Flash serial clock, idles low |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Values driven on the flash data lines |
| io_oe | output | 4 | Output enables of the flash data lines |
| io_in | input | 4 | Values received from the flash data lines |

## Verification
Several rules are checked by assertions on every cycle:
- The clock idles low while chip select is high.
- Chip select stays high for at least one flash period between transfers.
- Exactly 32 rising clock edges occur before IO0 is released.
- No nibble is launched before the 40th rising edge.
- The main read only runs at a delay that passed calibration, and the error flag never coexists with an active transfer.

Other behaviour can only be shown by the bench scenarios, which use a flash model with adjustable return latency and per-read corruption:
- that the chosen delay is the centre of the real window, including a window that touches the top tap, a split window and a tie;
- that the streamed bytes match the image;
- that a zero count skips the main read;
- that a start issued mid-run is ignored.

// File: rtl/qbr_pkg.sv
package qbr_pkg;
    localparam int DLY_W      = 4;
    localparam int TAPS       = 1 << DLY_W;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int HDR_BITS   = CMD_BITS + ADDR_BITS;
    localparam int DUMMY_CLKS = 8;
    localparam logic [CMD_BITS-1:0] READ_OP = 8'h6B;

    typedef enum logic [2:0] {
        X_IDLE, X_CMD, X_ADDR, X_DUMMY, X_DATA, X_DRAIN, X_GAP
    } xfer_state_t;

    typedef enum logic [2:0] {
        C_IDLE, C_CAL_RUN, C_CAL_NEXT, C_MAIN_RUN, C_FINISH
    } ctl_state_t;
endpackage

// File: rtl/qbr_xfer.sv
module qbr_xfer
    import qbr_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] nbytes,
    output logic             sclk,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic             launch,
    output logic             fin
);
    localparam int PH_W = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
    localparam int SC_W = (CNT_W + 1 > 6) ? CNT_W + 1 : 6;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_DIV);

    xfer_state_t state_q, state_d;
    logic [PH_W-1:0]     ph_q;
    logic [SC_W-1:0]     sc_q;
    logic [SC_W-1:0]     nib_last_q;
    logic [HDR_BITS-1:0] sh_q;
    logic                slot_end;

    assign slot_end = (ph_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= X_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            X_IDLE:  if (go) state_d = X_CMD;
            X_CMD:   if (slot_end && sc_q == SC_W'(CMD_BITS - 1)) state_d = X_ADDR;
            X_ADDR:  if (slot_end && sc_q == SC_W'(ADDR_BITS - 1)) state_d = X_DUMMY;
            X_DUMMY: if (slot_end && sc_q == SC_W'(DUMMY_CLKS - 1)) state_d = X_DATA;
            X_DATA:  if (slot_end && sc_q == nib_last_q) state_d = X_DRAIN;
            X_DRAIN: if (sc_q == SC_W'(TAPS - 1)) state_d = X_GAP;
            X_GAP:   if (slot_end) state_d = X_IDLE;
            default: state_d = X_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q       <= '0;
            sc_q       <= '0;
            nib_last_q <= '0;
            sh_q       <= '0;
        end else begin
            if (state_q == X_IDLE && go) begin
                sh_q       <= {READ_OP, {ADDR_BITS{1'b0}}};
                nib_last_q <= SC_W'({nbytes, 1'b0}) - SC_W'(1);
            end else if ((state_q == X_CMD || state_q == X_ADDR) && slot_end) begin
                sh_q <= sh_q << 1;
            end
            if (state_d != state_q) begin
                ph_q <= '0;
                sc_q <= '0;
            end else if (state_q == X_DRAIN) begin
                sc_q <= sc_q + SC_W'(1);
            end else if (state_q != X_IDLE) begin
                ph_q <= slot_end ? '0 : ph_q + PH_W'(1);
                if (slot_end) sc_q <= sc_q + SC_W'(1);
            end
        end
    end

    always_comb begin
        cs_n   = (state_q == X_IDLE) || (state_q == X_GAP);
        sclk   = (state_q inside {X_CMD, X_ADDR, X_DUMMY, X_DATA}) && (ph_q >= PH_HALF);
        io_oe  = {3'b000, (state_q == X_CMD) || (state_q == X_ADDR)};
        io_out = {3'b000, io_oe[0] & sh_q[HDR_BITS-1]};
        launch = (state_q == X_DATA) && (ph_q == '0);
        fin    = (state_q == X_GAP) && slot_end;
    end

    localparam int HR_W = $clog2(2 * HALF_DIV + 1) + 1;
    localparam logic [HR_W-1:0] HR_LIM = HR_W'(2 * HALF_DIV);
    logic [7:0]      rise_cnt_q;
    logic            sclk_q;
    logic [HR_W-1:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
            sclk_q     <= 1'b0;
            hi_run_q   <= HR_LIM;
        end else begin
            sclk_q <= sclk;
            if (cs_n) rise_cnt_q <= '0;
            else if (sclk && !sclk_q && rise_cnt_q != 8'hFF) rise_cnt_q <= rise_cnt_q + 8'd1;
            if (!cs_n) hi_run_q <= '0;
            else if (hi_run_q < HR_LIM) hi_run_q <= hi_run_q + HR_W'(1);
        end
    end

    assert_hdr_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_oe[0]) |-> rise_cnt_q == 8'd32);
    assert_dummy_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> rise_cnt_q >= 8'd40);
    assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    assert_cs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_run_q >= HR_LIM);
endmodule

// File: rtl/qbr_capture.sv
module qbr_capture
    import qbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             launch,
    input  logic [DLY_W-1:0] delay,
    input  logic [3:0]       io_in,
    output logic             byte_valid,
    output logic [7:0]       byte_data
);
    logic [TAPS-2:0] strb_q;
    logic [TAPS-1:0] taps;
    logic            fire;
    logic            half_q;
    logic [3:0]      hi_q;

    assign taps = {strb_q, launch};
    assign fire = taps[delay];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q     <= '0;
            half_q     <= 1'b0;
            hi_q       <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clear) begin
                strb_q <= '0;
                half_q <= 1'b0;
            end else begin
                strb_q <= {strb_q[TAPS-3:0], launch};
                if (fire) begin
                    if (!half_q) begin
                        hi_q   <= io_in;
                        half_q <= 1'b1;
                    end else begin
                        byte_data  <= {hi_q, io_in};
                        byte_valid <= 1'b1;
                        half_q     <= 1'b0;
                    end
                end
            end
        end
    end

    assert_byte_two_nibbles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

// File: rtl/qbr_window.sv
module qbr_window
    import qbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             res_valid,
    input  logic             res_pass,
    input  logic [DLY_W-1:0] res_idx,
    output logic             any_pass,
    output logic [DLY_W-1:0] pick
);
    logic [DLY_W-1:0] cur_start_q, best_start_q, run_start;
    logic [DLY_W:0]   cur_len_q, best_len_q, run_len, half_span, centre;

    assign run_len   = cur_len_q + (DLY_W+1)'(1);
    assign run_start = (cur_len_q == '0) ? res_idx : cur_start_q;
    assign half_span = (best_len_q - (DLY_W+1)'(1)) >> 1;
    assign centre    = {1'b0, best_start_q} + half_span;
    assign pick      = centre[DLY_W-1:0];
    assign any_pass  = (best_len_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (clear) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (res_valid) begin
            if (res_pass) begin
                cur_len_q   <= run_len;
                cur_start_q <= run_start;
                if (run_len > best_len_q) begin
                    best_len_q   <= run_len;
                    best_start_q <= run_start;
                end
            end else begin
                cur_len_q <= '0;
            end
        end
    end

    assert_pass_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_pass && !clear |=> any_pass);
endmodule

// File: rtl/qspi_boot_reader.sv
module qspi_boot_reader
    import qbr_pkg::*;
#(
    parameter int                HALF_DIV  = 2,
    parameter int                CNT_W     = 16,
    parameter int                SIG_W     = 32,
    parameter logic [SIG_W-1:0]  SIGNATURE = 32'hA5C3_9E17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             done,
    output logic             cal_err,
    output logic [DLY_W-1:0] cal_delay,
    output logic             sclk,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    localparam int SIG_BYTES = SIG_W / 8;
    localparam int BI_W      = $clog2(SIG_BYTES + 1);

    ctl_state_t state_q, state_d;
    logic [DLY_W-1:0] dly_q;
    logic [BI_W-1:0]  bidx_q;
    logic             miss_q, err_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAPS-1:0]  pass_mask_q;

    logic             xfer_go, xfer_fin, launch;
    logic [CNT_W-1:0] xfer_n;
    logic             res_valid, res_pass, run_clear;
    logic             cap_valid;
    logic [7:0]       cap_byte;
    logic             any_pass;
    logic [DLY_W-1:0] pick;
    logic [SIG_W-1:0] sig_cur;
    logic             last_dly;

    assign sig_cur  = SIGNATURE << {bidx_q, 3'b000};
    assign last_dly = (dly_q == {DLY_W{1'b1}});

    qbr_xfer #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .go(xfer_go), .nbytes(xfer_n),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
        .launch(launch), .fin(xfer_fin)
    );

    qbr_capture u_cap (
        .clk(clk), .rst_n(rst_n), .clear(xfer_go), .launch(launch),
        .delay(dly_q), .io_in(io_in), .byte_valid(cap_valid), .byte_data(cap_byte)
    );

    qbr_window u_win (
        .clk(clk), .rst_n(rst_n), .clear(run_clear), .res_valid(res_valid),
        .res_pass(res_pass), .res_idx(dly_q), .any_pass(any_pass), .pick(pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        xfer_go   = 1'b0;
        xfer_n    = CNT_W'(SIG_BYTES);
        res_valid = 1'b0;
        res_pass  = 1'b0;
        run_clear = 1'b0;
        unique case (state_q)
            C_IDLE: if (start) begin
                state_d   = C_CAL_RUN;
                xfer_go   = 1'b1;
                run_clear = 1'b1;
            end
            C_CAL_RUN: if (xfer_fin) begin
                res_valid = 1'b1;
                res_pass  = !miss_q && (bidx_q == BI_W'(SIG_BYTES));
                state_d   = C_CAL_NEXT;
            end
            C_CAL_NEXT: begin
                if (!last_dly) begin
                    xfer_go = 1'b1;
                    state_d = C_CAL_RUN;
                end else if (!any_pass) begin
                    state_d = C_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = C_FINISH;
                end else begin
                    xfer_go = 1'b1;
                    xfer_n  = cnt_q;
                    state_d = C_MAIN_RUN;
                end
            end
            C_MAIN_RUN: if (xfer_fin) state_d = C_FINISH;
            C_FINISH:   state_d = C_IDLE;
            default:    state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q       <= '0;
            bidx_q      <= '0;
            miss_q      <= 1'b0;
            err_q       <= 1'b0;
            cnt_q       <= '0;
            pass_mask_q <= '0;
        end else begin
            unique case (state_q)
                C_IDLE: if (start) begin
                    dly_q       <= '0;
                    err_q       <= 1'b0;
                    cnt_q       <= byte_count;
                    bidx_q      <= '0;
                    miss_q      <= 1'b0;
                    pass_mask_q <= '0;
                end
                C_CAL_RUN: begin
                    if (cap_valid) begin
                        if (bidx_q < BI_W'(SIG_BYTES)) begin
                            if (cap_byte != sig_cur[SIG_W-1 -: 8]) miss_q <= 1'b1;
                            bidx_q <= bidx_q + BI_W'(1);
                        end else begin
                            miss_q <= 1'b1;
                        end
                    end
                    if (res_valid && res_pass) pass_mask_q[dly_q] <= 1'b1;
                end
                C_CAL_NEXT: begin
                    bidx_q <= '0;
                    miss_q <= 1'b0;
                    if (!last_dly)     dly_q <= dly_q + DLY_W'(1);
                    else if (any_pass) dly_q <= pick;
                    else               err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        out_valid = (state_q == C_MAIN_RUN) && cap_valid;
        out_data  = cap_byte;
        done      = (state_q == C_FINISH);
        cal_err   = err_q;
        cal_delay = dly_q;
    end

    assert_main_delay_passed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == C_MAIN_RUN |-> pass_mask_q[dly_q]);
    assert_err_no_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> cs_n && !out_valid);
endmodule

// File: tb/qspi_boot_reader_test.sv
module qspi_boot_reader_test;
    localparam int CNT_W = 16;
    localparam int HALF  = 2;
    localparam logic [31:0] SIG = 32'hA5C3_9E17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic             out_valid, done, cal_err, sclk, cs_n;
    logic [7:0]       out_data;
    logic [3:0]       cal_delay, io_out, io_oe, io_in;

    always #4 clk = ~clk;

    qspi_boot_reader #(.HALF_DIV(HALF), .CNT_W(CNT_W), .SIGNATURE(SIG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .out_valid(out_valid), .out_data(out_data), .done(done), .cal_err(cal_err),
        .cal_delay(cal_delay), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input int j);
        if (j < 4) return 8'(SIG >> (8 * (3 - j)));
        return 8'(j * 29 + 7);
    endfunction

    // flash model
    logic [3:0]  lat = 4'd3;
    logic [16:0] bad_mask = '0;
    logic [4:0]  tcount = '0;
    int          rises = 0, fidx = 0, hi_run = 100, last_rise = 0, cyc = 0;
    logic [31:0] cmd_sh = '0;
    bit          hdr_bad = 0, oe_bad = 0, per_bad = 0;
    logic        cs_q = 1'b1, sclk_q = 1'b0;
    logic [3:0]  dv = '0;
    logic [3:0]  hist [0:15];
    logic [7:0]  b;

    initial for (int k = 0; k < 16; k++) hist[k] = '0;
    assign io_in = hist[lat];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_n) begin
                if (!cs_q) begin
                    check(cmd_sh == 32'h6B00_0000 && !hdr_bad, "R1", "opcode/address bits", int'(cmd_sh), 32'h6B00_0000);
                    check(!oe_bad && rises >= 40, "R2", "dummy/data enables", rises, 40);
                    check(!per_bad, "R3", "sclk period", 0, 0);
                    tcount = tcount + 5'd1;
                end
                if (sclk) per_bad = 1;
                hi_run++;
                rises = 0; fidx = 0; dv = '0;
            end else begin
                if (cs_q) begin
                    if (tcount != 0) check(hi_run >= 2 * HALF, "R4", "cs_n high gap", hi_run, 2 * HALF);
                    hi_run = 0; hdr_bad = 0; oe_bad = 0; per_bad = 0; cmd_sh = '0;
                end
                if (sclk && !sclk_q) begin
                    if (rises > 0 && cyc - last_rise != 2 * HALF) per_bad = 1;
                    last_rise = cyc;
                    if (rises < 32) begin
                        cmd_sh = {cmd_sh[30:0], io_out[0]};
                        if (io_oe != 4'b0001) hdr_bad = 1;
                    end else if (io_oe != 4'b0000) oe_bad = 1;
                    rises++;
                end
                if (!sclk && sclk_q && rises >= 40) begin
                    b = mem_byte(fidx / 2) ^ (bad_mask[tcount] ? 8'hFF : 8'h00);
                    dv = (fidx % 2 == 0) ? b[7:4] : b[3:0];
                    fidx++;
                end
            end
        end
        cs_q = cs_n;
        sclk_q = sclk;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = dv;
    end

    // scoreboard
    logic [7:0] exp_q [$];
    int         done_cnt = 0;
    bit         expect_none = 0;
    logic [7:0] e;

    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && out_valid) begin
            if (tcount < 5'd16) check(0, "R12", "out_valid during calibration", 1, 0);
            if (expect_none) check(0, "R8", "out_valid after failed calibration", 1, 0);
            if (exp_q.size() == 0) check(0, "R9", "unexpected byte", int'(out_data), 0);
            else begin
                e = exp_q.pop_front();
                check(out_data == e, "R9", "boot byte", int'(out_data), int'(e));
            end
        end
    end

    task automatic push_expected(input int n);
        for (int j = 0; j < n; j++) exp_q.push_back(mem_byte(j));
    endtask

    task automatic run_case(input logic [3:0] l, input logic [16:0] mask, input int n,
                            input bit exp_err, input logic [3:0] exp_dly, input bit poke, input string req);
        int wd;
        lat = l; bad_mask = mask; tcount = '0; done_cnt = 0; expect_none = exp_err;
        if (!exp_err) push_expected(n);
        @(negedge clk); byte_count = CNT_W'(n); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            byte_count = CNT_W'(5); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wd = 0;
        while (done_cnt == 0 && !cal_err && wd < 20000) begin
            @(negedge clk); wd++;
        end
        check(wd < 20000, req, "watchdog", wd, 20000);
        repeat (30) @(negedge clk);
        check(cal_err == exp_err, "R8", "cal_err", int'(cal_err), int'(exp_err));
        if (!exp_err) check(cal_delay == exp_dly, req, "chosen delay", int'(cal_delay), int'(exp_dly));
        check(done_cnt == (exp_err ? 0 : 1), "R9", "done pulses", done_cnt, exp_err ? 0 : 1);
        check(int'(tcount) == ((exp_err || n == 0) ? 16 : 17), "R6", "transfer count", int'(tcount), (exp_err || n == 0) ? 16 : 17);
        check(exp_q.size() == 0, "R9", "bytes outstanding", exp_q.size(), 0);
        exp_q.delete();
        expect_none = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'b0000, "R3", "reset pins", int'({cs_n, sclk, io_oe}), 32);
        check(!done && !cal_err && !out_valid, "R3", "reset flags", int'({done, cal_err, out_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R5 R7: window 3..6 -> 4
        run_case(4'd3, 17'h0, 12, 1'b0, 4'd4, 1'b0, "R5 R7 window 3..6");
        // R5: window 10..13 -> 11
        run_case(4'd10, 17'h0, 20, 1'b0, 4'd11, 1'b0, "R5 window 10..13");
        // R7: window touching top tap 13..15 -> 14
        run_case(4'd13, 17'h0, 7, 1'b0, 4'd14, 1'b0, "R7 top window");
        // R7: split window {3},{5,6} -> 5
        run_case(4'd3, 17'h00010, 6, 1'b0, 4'd5, 1'b0, "R7 split window");
        // R7: tie {3},{5} -> lowest run, 3
        run_case(4'd3, 17'h00050, 4, 1'b0, 4'd3, 1'b0, "R7 tie");
        // R8: every header read corrupted
        run_case(4'd3, 17'h0FFFF, 8, 1'b1, 4'd0, 1'b0, "R8 all fail");
        // R10: zero count, error cleared by new start
        run_case(4'd3, 17'h0, 0, 1'b0, 4'd4, 1'b0, "R10 zero count");
        // R11: start while busy ignored
        run_case(4'd3, 17'h0, 9, 1'b0, 4'd4, 1'b1, "R11 start while busy");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule